// File: doc/BRIEF.md
# BCD Calendar Timekeeper Core

This block keeps wall-clock time and calendar date for a larger chip. A clock enable that pulses at 32.768 kHz is divided down to a one-second tick. That tick advances a set of packed-BCD counters: seconds, minutes, 24-hour hours, a day-of-week ring, date, month and a two-digit year. The date counter knows each month's length, and it gives February 29 days in every year whose two-digit value is a multiple of four. A one-cycle register port connects the core to a serial bus front end.

Software never touches the running counters directly. It sees a user copy. The copy follows the core while idle, and a capture bit freezes a coherent snapshot of it. A lock bit lets software compose a new time in the copy and commit it to the core in one step. The block also provides an oscillator-halt bit, a sticky flag for the year wrapping past 99, and a signed digital trim of the divider. While the calibration mode is on, a square wave derived from the divider chain is output so that its frequency can be measured.

Top module: `rtc_timekeeper`

## Requirements
- R1: With a zero trim code, the core advances one second after every DIV asserted cycles of `tick_en`. A commit restarts the divider, so the first tick after a commit lands on the DIV-th enable.
- R2: Seconds (address 2), minutes (3) and hours (4) are packed BCD with the units digit in bits 3:0. They roll 59→00, 59→00 and 23→00, and a full carry chain resolves within one tick.
- R3: The day-of-week field (address 5) counts 1..7 and wraps to 1 at each date change. The date field (6) rolls to 01 after day 31, 30 or 28, or after day 29 for February in years divisible by four. The month field (7) rolls 12→01, and the year field (8) rolls 99→00.
- R4: Writing bit 0 of address 0 from 0 to 1 loads the user copy with the core value, including a tick falling in that same cycle. The copy then stays frozen while the bit remains 1, and writing 1 again does not capture again.
- R5: While bit 1 of address 0 is 1, writes to addresses 2..8 update the user copy. Writing that bit back to 0 loads the copy into the core. Writes to addresses 2..8 while bit 1 is 0 are ignored.
- R6: Bit 3 of address 0 is read-only. It becomes 1 when the year wraps from 99 to 00, and it is cleared by a read of address 0; that read still returns the 1.
- R7: Bit 7 of address 1 halts the divider and the calendar while it is 1. It is 1 after reset.
- R8: The trim code (address 1 bits 4:0) and its sign (bit 5) change only on writes made while the calibration mode bit (address 0 bit 2) is 1.
- R9: In each 64-second window, the first `code` seconds are two enables shorter when the sign is 1, or two enables longer when the sign is 0.
- R10: `sqw_o` is low while the calibration mode is off. While it is on, `sqw_o` follows divider bit max(log2(DIV)−10, 0), which gives 512 Hz for DIV = 32768.
- R11: Read data appears on `reg_rdata` on the clock edge after `reg_rd` and holds until the next read. Addresses 9..15 read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz time-base enable, one cycle per pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| sqw_o | output | 1 | Calibration square wave, low when calibration mode is off |

## Verification
The hardest case to reach from the ports is a capture edge that coincides exactly with a divider tick, where the snapshot must already show the new second. The bench makes that cycle reachable because a commit zeroes the divider. After a commit it counts edges and places the capture write exactly DIV edges later, then one edge earlier, and the same arithmetic pins down the shortened and stretched seconds of the trim. The calendar is covered by committing the last second of every month of all hundred years with a small divider and comparing the result against month lengths computed in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                       dow: 8'h01, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

  // One BCD step: {carry, next}. Wraps to 'first' after 'last'.
  function automatic logic [8:0] bcd_step(logic [7:0] v, logic [7:0] last,
                                          logic [7:0] first);
    if (v == last) return {1'b1, first};
    if (v[3:0] == 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last valid date of a month, both arguments in BCD.
  function automatic logic [7:0] month_last(logic [7:0] mon, logic [7:0] yr);
    logic leap;
    if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV      = 32768,
  parameter int CODE_W   = 5,
  parameter int WIN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              sq_en_i,
  input  logic              sign_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o,
  output logic              sq_o
);
  localparam int LOGD   = $clog2(DIV);
  localparam int PW     = $clog2(DIV + 2);
  localparam int SQ_BIT = (LOGD > 10) ? LOGD - 10 : 0;
  localparam logic [PW-1:0] LAST_NOM  = PW'(DIV - 1);
  localparam logic [PW-1:0] LAST_FAST = PW'(DIV - 3);
  localparam logic [PW-1:0] LAST_SLOW = PW'(DIV + 1);

  logic [PW-1:0]       pre_q;
  logic [WIN_BITS-1:0] win_q;
  logic [WIN_BITS-1:0] code_ext;
  logic                trim_act;
  logic [PW-1:0]       last;
  logic                sq_q;

  assign code_ext = WIN_BITS'(code_i);
  assign trim_act = (win_q < code_ext);

  always_comb begin
    if (!trim_act)   last = LAST_NOM;
    else if (sign_i) last = LAST_FAST;
    else             last = LAST_SLOW;
  end

  assign tick_o = en_i && (pre_q == last);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (en_i) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) win_q <= win_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sq_q <= 1'b0;
    else     sq_q <= sq_en_i && pre_q[SQ_BIT];
  end
  assign sq_o = sq_q;

  assert_pre_range_R1: assert property (@(posedge clk) disable iff (rst)
    pre_q <= LAST_SLOW);
  assert_tick_gap_R9: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cur_o,
  output rtc_time_t nxt_o,
  output logic      cent_evt_o
);
  rtc_time_t  cur_q, adv;
  logic [8:0] st_s, st_m, st_h, st_w, st_d, st_mo, st_y;
  logic       yr_wrap;

  always_comb begin
    adv   = cur_q;
    st_m  = '0;
    st_h  = '0;
    st_w  = '0;
    st_d  = '0;
    st_mo = '0;
    st_y  = '0;
    yr_wrap = 1'b0;
    st_s    = bcd_step(cur_q.sec, 8'h59, 8'h00);
    adv.sec = st_s[7:0];
    if (st_s[8]) begin
      st_m    = bcd_step(cur_q.min, 8'h59, 8'h00);
      adv.min = st_m[7:0];
      if (st_m[8]) begin
        st_h     = bcd_step(cur_q.hour, 8'h23, 8'h00);
        adv.hour = st_h[7:0];
        if (st_h[8]) begin
          st_w     = bcd_step(cur_q.dow, 8'h07, 8'h01);
          adv.dow  = st_w[7:0];
          st_d     = bcd_step(cur_q.date, month_last(cur_q.mon, cur_q.year), 8'h01);
          adv.date = st_d[7:0];
          if (st_d[8]) begin
            st_mo   = bcd_step(cur_q.mon, 8'h12, 8'h01);
            adv.mon = st_mo[7:0];
            if (st_mo[8]) begin
              st_y     = bcd_step(cur_q.year, 8'h99, 8'h00);
              adv.year = st_y[7:0];
              yr_wrap  = st_y[8];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cur_q <= TIME_RESET;
    else if (load_i) cur_q <= load_val_i;
    else if (tick_i) cur_q <= adv;
  end

  assign cur_o      = cur_q;
  assign nxt_o      = tick_i ? adv : cur_q;
  assign cent_evt_o = tick_i && yr_wrap && !load_i;

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));
  assert_date_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !load_i && cur_q.sec == 8'h59 && cur_q.min == 8'h59 &&
     cur_q.hour == 8'h23 && cur_q.date == month_last(cur_q.mon, cur_q.year))
    |=> (cur_q.date == 8'h01));
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cur_q));
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int AW     = 4,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         core_nxt_i,
  input  logic              cent_evt_i,
  output logic [7:0]        rdata_o,
  output rtc_time_t         user_o,
  output logic              commit_o,
  output logic              halt_o,
  output logic              calm_o,
  output logic              sign_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_TRIM = AW'(1);
  localparam logic [AW-1:0] A_SEC  = AW'(2);
  localparam logic [AW-1:0] A_MIN  = AW'(3);
  localparam logic [AW-1:0] A_HOUR = AW'(4);
  localparam logic [AW-1:0] A_DOW  = AW'(5);
  localparam logic [AW-1:0] A_DATE = AW'(6);
  localparam logic [AW-1:0] A_MON  = AW'(7);
  localparam logic [AW-1:0] A_YEAR = AW'(8);

  logic cap_q, lock_q, calm_q, cent_q, halt_q, sign_q;
  logic [CODE_W-1:0] code_q;
  rtc_time_t user_q;
  logic [7:0] rdata_q, rd_mux, trim_byte;
  logic wr_ctrl, cap_rise, wr_time;

  assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
  assign cap_rise = wr_ctrl && wdata_i[0] && !cap_q;
  assign commit_o = wr_ctrl && lock_q && !wdata_i[1];
  assign wr_time  = wr_i && lock_q && (addr_i >= A_SEC) && (addr_i <= A_YEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= 1'b0;
      lock_q <= 1'b0;
      calm_q <= 1'b0;
      halt_q <= 1'b1;
      sign_q <= 1'b0;
      code_q <= '0;
    end else begin
      if (wr_ctrl) begin
        cap_q  <= wdata_i[0];
        lock_q <= wdata_i[1];
        calm_q <= wdata_i[2];
      end
      if (wr_i && addr_i == A_TRIM) begin
        halt_q <= wdata_i[7];
        if (calm_q) begin
          sign_q <= wdata_i[5];
          code_q <= wdata_i[CODE_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              cent_q <= 1'b0;
    else if (cent_evt_i)                  cent_q <= 1'b1;
    else if (rd_i && addr_i == A_CTRL)    cent_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      user_q <= TIME_RESET;
    end else if (cap_rise) begin
      user_q <= core_nxt_i;
    end else if (wr_time) begin
      case (addr_i)
        A_SEC:   user_q.sec  <= wdata_i;
        A_MIN:   user_q.min  <= wdata_i;
        A_HOUR:  user_q.hour <= wdata_i;
        A_DOW:   user_q.dow  <= wdata_i;
        A_DATE:  user_q.date <= wdata_i;
        A_MON:   user_q.mon  <= wdata_i;
        default: user_q.year <= wdata_i;
      endcase
    end else if (!cap_q && !lock_q) begin
      user_q <= core_nxt_i;
    end
  end

  always_comb begin
    trim_byte = '0;
    trim_byte[7] = halt_q;
    trim_byte[5] = sign_q;
    trim_byte[CODE_W-1:0] = code_q;
    case (addr_i)
      A_CTRL:  rd_mux = {4'b0000, cent_q, calm_q, lock_q, cap_q};
      A_TRIM:  rd_mux = trim_byte;
      A_SEC:   rd_mux = user_q.sec;
      A_MIN:   rd_mux = user_q.min;
      A_HOUR:  rd_mux = user_q.hour;
      A_DOW:   rd_mux = user_q.dow;
      A_DATE:  rd_mux = user_q.date;
      A_MON:   rd_mux = user_q.mon;
      A_YEAR:  rd_mux = user_q.year;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign user_o  = user_q;
  assign halt_o  = halt_q;
  assign calm_o  = calm_q;
  assign sign_o  = sign_q;
  assign code_o  = code_q;

  assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (cap_q && !lock_q) |=> $stable(user_q));
  assert_trim_guard_R8: assert property (@(posedge clk) disable iff (rst)
    !calm_q |=> $stable({sign_q, code_q}));
  assert_cent_set_R6: assert property (@(posedge clk) disable iff (rst)
    cent_evt_i |=> cent_q);
  assert_cent_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == A_CTRL && !cent_evt_i) |=> !cent_q);
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int DIV      = 32768,
  parameter int AW       = 4,
  parameter int CODE_W   = 5,
  parameter int WIN_BITS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          sqw_o
);
  rtc_time_t         core_cur, core_nxt, user_w;
  logic              commit_w, halt_w, calm_w, sign_w, tick_w, cent_w;
  logic [CODE_W-1:0] code_w;

  rtc_regs #(.AW(AW), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .core_nxt_i(core_nxt), .cent_evt_i(cent_w),
    .rdata_o(reg_rdata), .user_o(user_w), .commit_o(commit_w),
    .halt_o(halt_w), .calm_o(calm_w), .sign_o(sign_w), .code_o(code_w)
  );

  rtc_prescaler #(.DIV(DIV), .CODE_W(CODE_W), .WIN_BITS(WIN_BITS)) div_i (
    .clk(clk), .rst(rst), .en_i(tick_en && !halt_w), .clr_i(commit_w),
    .sq_en_i(calm_w), .sign_i(sign_w), .code_i(code_w),
    .tick_o(tick_w), .sq_o(sqw_o)
  );

  rtc_calendar cal_i (
    .clk(clk), .rst(rst), .tick_i(tick_w), .load_i(commit_w),
    .load_val_i(user_w), .cur_o(core_cur), .nxt_o(core_nxt),
    .cent_evt_o(cent_w)
  );

  assert_commit_load_R5: assert property (@(posedge clk) disable iff (rst)
    commit_w |=> (core_cur == $past(user_w)));
  assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (halt_w && !commit_w) |=> $stable(core_cur));
endmodule

// File: tb/rtc_timekeeper_tb.sv
module rtc_timekeeper_tb_top;
  localparam int DIV = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sqw_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] ctl = 8'h00;

  always #5 clk = ~clk;

  rtc_timekeeper #(.DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sqw_o(sqw_o)
  );

  function automatic logic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] mi,
                          input logic [7:0] h, input logic [7:0] dw,
                          input logic [7:0] d, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(4'd0, ctl | 8'h02);
    wr(4'd2, s); wr(4'd3, mi); wr(4'd4, h); wr(4'd5, dw);
    wr(4'd6, d); wr(4'd7, mo); wr(4'd8, y);
    wr(4'd0, ctl);
  endtask

  // Capture lands exactly k edges after the commit edge.
  task automatic snap(input int k);
    repeat (k - 1) @(negedge clk);
    wr(4'd0, ctl | 8'h01);
  endtask

  task automatic sec_after(input int k, input logic [7:0] s0,
                           input logic [7:0] exp, input string tag);
    logic [7:0] v;
    set_time(s0, 8'h00, 8'h10, 8'h01, 8'h05, 8'h05, 8'h20);
    snap(k);
    rd(4'd2, v);
    check(tag, v, exp);
    wr(4'd0, ctl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int tg;
    logic prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    check("R10 reset sqw low", sqw_o, 0);
    rd(4'd0, v); check("R4 reset ctrl", v, 8'h00);
    rd(4'd1, v); check("R7 reset halt set", v, 8'h80);
    rd(4'd2, v); check("R2 reset seconds", v, 8'h00);
    rd(4'd6, v); check("R3 reset date", v, 8'h01);
    rd(4'd5, v); check("R3 reset dow", v, 8'h01);
    rd(4'd15, v); check("R11 unused addr 15", v, 8'h00);
    rd(4'd9, v); check("R11 unused addr 9", v, 8'h00);

    wr(4'd1, 8'h00);

    // R1 divider timing and R4 pending tick folded into capture
    sec_after(DIV - 1, 8'h10, 8'h10, "R1 before first tick");
    sec_after(DIV, 8'h10, 8'h11, "R4 capture on tick edge");
    sec_after(2 * DIV, 8'h10, 8'h12, "R1 second tick");

    // R4 frozen snapshot, no recapture, R5 ignored write
    set_time(8'h30, 8'h00, 8'h10, 8'h01, 8'h05, 8'h05, 8'h20);
    snap(DIV);
    repeat (3 * DIV) @(negedge clk);
    rd(4'd2, v); check("R4 snapshot frozen", v, 8'h31);
    wr(4'd0, ctl | 8'h01);
    rd(4'd2, v); check("R4 no recapture on held bit", v, 8'h31);
    wr(4'd2, 8'h42);
    rd(4'd2, v); check("R5 write ignored while unlocked", v, 8'h31);
    wr(4'd0, ctl);

    // R2 cascades
    set_time(8'h56, 8'h34, 8'h12, 8'h03, 8'h15, 8'h06, 8'h21);
    snap(DIV);
    rd(4'd2, v); check("R2 plain second", v, 8'h57);
    rd(4'd3, v); check("R2 minute unchanged", v, 8'h34);
    wr(4'd0, ctl);
    set_time(8'h59, 8'h59, 8'h10, 8'h03, 8'h15, 8'h06, 8'h21);
    snap(DIV);
    rd(4'd4, v); check("R2 hour carry", v, 8'h11);
    rd(4'd3, v); check("R2 minute wrap", v, 8'h00);
    wr(4'd0, ctl);

    // R6 century flag and R3 dow wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    snap(DIV);
    rd(4'd0, v); check("R6 flag set on year wrap", v, 8'h09);
    rd(4'd0, v); check("R6 flag cleared by read", v, 8'h01);
    rd(4'd8, v); check("R3 year wrap", v, 8'h00);
    rd(4'd5, v); check("R3 dow ring wrap", v, 8'h01);
    wr(4'd0, ctl);

    // R7 halt
    wr(4'd1, 8'h80);
    set_time(8'h20, 8'h00, 8'h10, 8'h01, 8'h05, 8'h05, 8'h20);
    snap(3 * DIV);
    rd(4'd2, v); check("R7 halted core holds", v, 8'h20);
    wr(4'd0, ctl);
    wr(4'd1, 8'h00);

    // R8 trim write guard
    wr(4'd1, 8'h3F);
    rd(4'd1, v); check("R8 trim write blocked", v, 8'h00);
    ctl = 8'h04;
    wr(4'd0, ctl);
    wr(4'd1, 8'h21);
    rd(4'd1, v); check("R8 trim write accepted", v, 8'h21);

    // R9 calibration: sign 1 shortens, sign 0 lengthens, first code seconds
    sec_after(DIV - 3, 8'h00, 8'h00, "R9 fast second not yet");
    sec_after(DIV - 2, 8'h00, 8'h01, "R9 fast second");
    sec_after(2 * DIV - 3, 8'h00, 8'h01, "R9 window second normal early");
    sec_after(2 * DIV - 2, 8'h00, 8'h02, "R9 window second normal");
    wr(4'd1, 8'h01);
    sec_after(DIV + 1, 8'h00, 8'h00, "R9 slow second not yet");
    sec_after(DIV + 2, 8'h00, 8'h01, "R9 slow second");
    wr(4'd1, 8'h00);

    // R10 square wave
    tg = 0; prev = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0 && sqw_o != prev) tg++;
      prev = sqw_o;
    end
    check("R10 square wave toggles", tg, 7);
    ctl = 8'h00;
    wr(4'd0, ctl);
    repeat (2) @(negedge clk);
    tg = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sqw_o) tg++;
    end
    check("R10 square wave off", tg, 0);

    // R3 month-end sweep over all hundred years
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int dw;
        int len;
        dw = ((y + m) % 7) + 1;
        len = mlen(m, y);
        set_time(8'h59, 8'h59, 8'h23, bcd(dw), bcd(len), bcd(m), bcd(y));
        snap(DIV);
        rd(4'd6, v); check("R3 date rolls to 01", v, 8'h01);
        rd(4'd7, v); check("R3 month advance", v, bcd((m == 12) ? 1 : m + 1));
        rd(4'd8, v); check("R3 year value", v, bcd((m == 12) ? (y + 1) % 100 : y));
        rd(4'd5, v); check("R3 dow advance", v, bcd(dw % 7 + 1));
        rd(4'd4, v); check("R2 hour wrap", v, 8'h00);
        wr(4'd0, ctl);
        if (m == 2) begin
          set_time(8'h59, 8'h59, 8'h23, 8'h01, bcd(len - 1), 8'h02, bcd(y));
          snap(DIV);
          rd(4'd6, v); check("R3 february last day kept", v, bcd(len));
          rd(4'd7, v); check("R3 february month kept", v, 8'h02);
          wr(4'd0, ctl);
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule